// File: doc/BRIEF.md
# Divided Word-Line Row Decoder

This block selects one row of a memory whose cell array is cut into several sub-arrays placed side by side. Row selection happens in two steps. The upper row address is first turned into one global main word-line. Each main word-line then meets the decoded sub-array number, so that only the one local sub-word-line inside the addressed sub-array is raised. The word-line and bit-line segments of the other sub-arrays stay idle. Each main line feeds one sub-word-line per sub-array, which is four with the default setting.

The row address is split into small groups of bits. Each group is decoded on its own into a one-hot predecode bus, and an AND over one line from each group forms the main line. This keeps the fan-in of the final gate small and spreads the load on the address inputs. All word-lines are gated by an access pulse, which normally comes from an address-transition detector. The row and sub-array addresses are captured in the clock cycle where the pulse is first seen high, and they are held until the pulse has been seen low. An address change in the middle of an access therefore cannot move a word-line.

Top module: `dwl_row_decoder`

## Requirements
- R1: While rst_n is low, main_wl_o, sub_wl_o and blk_sel_o are all zero, whatever the other inputs do.
- R2: While the registered pulse is low, all three outputs are zero, even when the address inputs change.
- R3: One clock edge after en_pulse_i is first sampled high, main_wl_o has only bit row_addr_i set.
- R4: In the same cycle, sub_wl_o has only bit (row_addr_i * NUM_BLOCKS + blk_addr_i) set. Sub-word-line k belongs to main line k / NUM_BLOCKS and to sub-array k % NUM_BLOCKS.
- R5: In the same cycle, blk_sel_o has only bit blk_addr_i set.
- R6: While en_pulse_i stays high after the first edge of an access, changes on row_addr_i and blk_addr_i have no effect. The captured row and sub-array keep driving the outputs.
- R7: One clock edge after en_pulse_i is sampled low, all word-line and select outputs return to zero.
- R8: At most one main line, one sub-word-line and one sub-array select are high at any time. The number of high sub-word-lines always equals the number of high main lines.
- R9: A new access that starts after a single low cycle of en_pulse_i captures the new address. It does not reuse the address of the previous access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_addr_i | input | ROW_BITS | Main row address |
| blk_addr_i | input | BLK_BITS | Sub-array address |
| en_pulse_i | input | 1 | Access pulse, high for the length of one access |
| main_wl_o | output | 2**ROW_BITS | One-hot global main word-lines |
| sub_wl_o | output | 2**(ROW_BITS+BLK_BITS) | One-hot local sub-word-lines |
| blk_sel_o | output | 2**BLK_BITS | One-hot sub-array select |

## Verification
A wrong captured address or a bad predecode line shows up at the ports one edge after the pulse is sampled high. It appears as the wrong main line, or as a sub-word-line outside the addressed row and sub-array. A capture register that reloads during the access shows up on the next edge, when the bench has scrambled the address inputs. A stuck access state shows up one edge after the pulse falls, as word-lines that stay high. Every row is swept against every sub-array, so any single bad predecode line or AND term is reached.

// File: rtl/dwl_pkg.sv
package dwl_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } acc_state_e;

  // number of predecode groups for a row address of row_w bits
  function automatic int num_groups(input int row_w, input int grp_w);
    return (row_w + grp_w - 1) / grp_w;
  endfunction

  // width of group g (the last group may be narrower)
  function automatic int group_width(input int row_w, input int grp_w, input int g);
    int rem;
    rem = row_w - g * grp_w;
    return (rem < grp_w) ? rem : grp_w;
  endfunction

  // total number of predecode lines over all groups
  function automatic int predecode_lines(input int row_w, input int grp_w);
    int n;
    n = 0;
    for (int g = 0; g < num_groups(row_w, grp_w); g++) begin
      n += (1 << group_width(row_w, grp_w, g));
    end
    return n;
  endfunction

endpackage

// File: rtl/dwl_addr_capture.sv
module dwl_addr_capture
  import dwl_pkg::*;
#(
  parameter int ROW_BITS = 5,
  parameter int BLK_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [ROW_BITS-1:0] row_i,
  input  logic [BLK_BITS-1:0] blk_i,
  output logic                active_o,
  output logic [ROW_BITS-1:0] row_o,
  output logic [BLK_BITS-1:0] blk_o
);

  acc_state_e          state_q, state_d;
  logic [ROW_BITS-1:0] row_q;
  logic [BLK_BITS-1:0] blk_q;
  logic                addr_load;

  // next state: follow the pulse; load address only at access start
  always_comb begin
    state_d   = en_i ? ST_ACTIVE : ST_IDLE;
    addr_load = (state_q == ST_IDLE) && en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      blk_q <= '0;
    end else if (addr_load) begin
      row_q <= row_i;
      blk_q <= blk_i;
    end
  end

  assign active_o = (state_q == ST_ACTIVE);
  assign row_o    = row_q;
  assign blk_o    = blk_q;

  // captured address may not move while the access continues
  assert_hold_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && en_i) |=> ($stable(row_q) && $stable(blk_q)));

  // a fresh access takes the address presented with the pulse
  assert_fresh_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && en_i) |=> (row_q == $past(row_i) && blk_q == $past(blk_i)));

endmodule

// File: rtl/dwl_predecode.sv
module dwl_predecode #(
  parameter int IN_BITS = 2,
  localparam int N_OUT  = 1 << IN_BITS
) (
  input  logic               en_i,
  input  logic [IN_BITS-1:0] code_i,
  output logic [N_OUT-1:0]   sel_o
);

  always_comb begin
    sel_o = '0;
    if (en_i) begin
      sel_o[code_i] = 1'b1;
    end
  end

endmodule

// File: rtl/dwl_main_stage.sv
module dwl_main_stage
  import dwl_pkg::*;
#(
  parameter int ROW_BITS = 5,
  parameter int GRP_BITS = 2,
  localparam int NGRP     = num_groups(ROW_BITS, GRP_BITS),
  localparam int PRE_N    = 1 << GRP_BITS,
  localparam int PRE_TOT  = predecode_lines(ROW_BITS, GRP_BITS),
  localparam int NUM_MAIN = 1 << ROW_BITS
) (
  input  logic [PRE_TOT-1:0]  pre_i,
  output logic [NUM_MAIN-1:0] main_o
);

  for (genvar r = 0; r < NUM_MAIN; r++) begin : g_row
    logic [NGRP-1:0] term;
    for (genvar g = 0; g < NGRP; g++) begin : g_term
      localparam int GW  = group_width(ROW_BITS, GRP_BITS, g);
      localparam int FLD = (r >> (g * GRP_BITS)) & ((1 << GW) - 1);
      assign term[g] = pre_i[g * PRE_N + FLD];
    end
    assign main_o[r] = &term;
  end

endmodule

// File: rtl/dwl_local_stage.sv
module dwl_local_stage #(
  parameter int NUM_MAIN = 32,
  parameter int NUM_BLK  = 4,
  localparam int NUM_SUB = NUM_MAIN * NUM_BLK
) (
  input  logic [NUM_MAIN-1:0] main_i,
  input  logic [NUM_BLK-1:0]  blk_sel_i,
  output logic [NUM_SUB-1:0]  sub_o
);

  for (genvar r = 0; r < NUM_MAIN; r++) begin : g_main
    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
      assign sub_o[r * NUM_BLK + b] = main_i[r] & blk_sel_i[b];
    end
  end

endmodule

// File: rtl/dwl_row_decoder.sv
module dwl_row_decoder
  import dwl_pkg::*;
#(
  parameter int ROW_BITS = 5,
  parameter int BLK_BITS = 2,
  parameter int GRP_BITS = 2,
  localparam int NUM_MAIN = 1 << ROW_BITS,
  localparam int NUM_BLK  = 1 << BLK_BITS,
  localparam int NUM_SUB  = NUM_MAIN * NUM_BLK,
  localparam int NGRP     = num_groups(ROW_BITS, GRP_BITS),
  localparam int PRE_N    = 1 << GRP_BITS,
  localparam int PRE_TOT  = predecode_lines(ROW_BITS, GRP_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ROW_BITS-1:0] row_addr_i,
  input  logic [BLK_BITS-1:0] blk_addr_i,
  input  logic                en_pulse_i,
  output logic [NUM_MAIN-1:0] main_wl_o,
  output logic [NUM_SUB-1:0]  sub_wl_o,
  output logic [NUM_BLK-1:0]  blk_sel_o
);

  logic                active;
  logic [ROW_BITS-1:0] row_q;
  logic [BLK_BITS-1:0] blk_q;
  logic [PRE_TOT-1:0]  pre_lines;

  dwl_addr_capture #(
    .ROW_BITS (ROW_BITS),
    .BLK_BITS (BLK_BITS)
  ) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_pulse_i),
    .row_i    (row_addr_i),
    .blk_i    (blk_addr_i),
    .active_o (active),
    .row_o    (row_q),
    .blk_o    (blk_q)
  );

  // row predecode, one small decoder per address group
  for (genvar g = 0; g < NGRP; g++) begin : g_pre
    localparam int GW = group_width(ROW_BITS, GRP_BITS, g);
    dwl_predecode #(.IN_BITS(GW)) u_pre (
      .en_i   (active),
      .code_i (row_q[g * GRP_BITS +: GW]),
      .sel_o  (pre_lines[g * PRE_N +: (1 << GW)])
    );
  end

  dwl_predecode #(.IN_BITS(BLK_BITS)) u_blk_dec (
    .en_i   (active),
    .code_i (blk_q),
    .sel_o  (blk_sel_o)
  );

  dwl_main_stage #(
    .ROW_BITS (ROW_BITS),
    .GRP_BITS (GRP_BITS)
  ) u_main (
    .pre_i  (pre_lines),
    .main_o (main_wl_o)
  );

  dwl_local_stage #(
    .NUM_MAIN (NUM_MAIN),
    .NUM_BLK  (NUM_BLK)
  ) u_local (
    .main_i    (main_wl_o),
    .blk_sel_i (blk_sel_o),
    .sub_o     (sub_wl_o)
  );

  assert_quiet_after_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_pulse_i |=> (main_wl_o == '0 && sub_wl_o == '0 && blk_sel_o == '0));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sub_wl_o == '0 && main_wl_o == '0));

  assert_single_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sub_wl_o) && $onehot0(main_wl_o) && $onehot0(blk_sel_o));

  assert_sub_tracks_main_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sub_wl_o) == $countones(main_wl_o));

  assert_main_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && en_pulse_i) |=> (main_wl_o == (NUM_MAIN'(1) << $past(row_addr_i))));

  assert_blk_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && en_pulse_i) |=> (blk_sel_o == (NUM_BLK'(1) << $past(blk_addr_i))));

endmodule

// File: tb/dwl_row_decoder_bench.sv
module dwl_row_decoder_bench;

  localparam int RB = 5;
  localparam int BB = 2;
  localparam int NM = 1 << RB;
  localparam int NB = 1 << BB;
  localparam int NS = NM * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [RB-1:0] row_addr;
  logic [BB-1:0] blk_addr;
  logic          en_pulse;
  logic [NM-1:0] main_wl;
  logic [NS-1:0] sub_wl;
  logic [NB-1:0] blk_sel;

  int checks   = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dwl_row_decoder #(.ROW_BITS(RB), .BLK_BITS(BB), .GRP_BITS(2)) u_dwl_row_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .row_addr_i (row_addr),
    .blk_addr_i (blk_addr),
    .en_pulse_i (en_pulse),
    .main_wl_o  (main_wl),
    .sub_wl_o   (sub_wl),
    .blk_sel_o  (blk_sel)
  );

  task automatic check(input string req, input logic [NS-1:0] act, input logic [NS-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int row, input int blk, input bit on);
    logic [NS-1:0] em, es, eb;
    em = '0; es = '0; eb = '0;
    if (on) begin
      em[row]          = 1'b1;
      es[row * NB + blk] = 1'b1;
      eb[blk]          = 1'b1;
    end
    check({req, " main"}, NS'(main_wl), em);
    check({req, " sub"},  sub_wl, es);
    check({req, " blk"},  NS'(blk_sel), eb);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en_pulse = 1'b0; row_addr = '0; blk_addr = '0;
    repeat (2) @(negedge clk);
    en_pulse = 1'b1; row_addr = 5'd9; blk_addr = 2'd3;
    @(negedge clk);
    check_all("R1 reset", 0, 0, 1'b0);
    en_pulse = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      row_addr = RB'(i * 7); blk_addr = BB'(i);
      @(negedge clk);
      check_all("R2 idle", 0, 0, 1'b0);
    end
    // exhaustive sweep; each access follows a single low cycle (R9)
    for (int r = 0; r < NM; r++) begin
      for (int b = 0; b < NB; b++) begin
        row_addr = RB'(r); blk_addr = BB'(b); en_pulse = 1'b1;
        @(negedge clk);
        check_all("R3 R4 R5 R9 start", r, b, 1'b1);
        check("R8 count", NS'($countones(sub_wl)), NS'(1));
        row_addr = ~RB'(r); blk_addr = BB'(b + 1);
        @(negedge clk);
        check_all("R6 hold", r, b, 1'b1);
        en_pulse = 1'b0; row_addr = RB'(r + 7); blk_addr = BB'(b + 2);
        @(negedge clk);
        check_all("R7 off", 0, 0, 1'b0);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule